// File: doc/BRIEF.md
# STS-12 Transmit Overhead Inserter

This block sits in the transmit path of one STS-12 channel, one byte per clock, ahead of a serializer. Each incoming payload byte carries a parity bit, which is checked against a selectable odd or even sense. A failure is flagged on the matching output byte, and the byte itself is not changed. Framing is timed only by a one-cycle frame pulse that marks the first byte of a 9720-byte frame. From that pulse the block can overwrite the framing bytes and place the BIP-8 of the previously transmitted frame in the B1 slot. It can then apply the frame-synchronous scrambler to everything outside the first overhead row.

Each stage has its own enable. Two settings are typical. With only framing insertion enabled, the block runs transparent: just the framing bytes change. With every stage off, no byte is altered. A separate pass-through control forwards input bytes unchanged whatever the other controls say. Deliberate errors can be injected into the framing bytes and into B1 so that the far-end monitors can be tested.

Both data edges are valid/ready streams. An input byte is taken on a clock where `in_valid` and `in_ready` are both high, and the frame pulse `in_sof` is sampled only on that clock. One output register holds the result. `in_ready` is high whenever that register is empty or is being drained on the same clock. The output byte, its error flag and `out_valid` hold still for as long as `out_ready` stays low. The frame position advances per accepted byte, not per clock.

Top module: `sonet_tx_oh_inserter`

## Requirements
- R1: An input byte accepted with `in_valid` and `in_ready` high appears on the output on the next clock, in order. `in_ready` is high whenever the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_perr` stay unchanged. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: With `par_odd`=1, a byte passes its check when its eight data bits plus `in_par` hold an odd number of ones. With `par_odd`=0 the count must be even. `out_perr` is 1 exactly on the output byte whose check failed, and the check never alters the byte.
- R3: A byte accepted with `in_sof`=1 is frame position 0, and a frame is 9720 bytes (positions 0 to 9719). Without a pulse the position wraps from 9719 to 0, and framing continues there. Until the first pulse after reset, no insertion or scrambling takes place.
- R4: With `frm_ins`=1, positions 0 to 11 are replaced by 0xF6 and positions 12 to 23 by 0x28.
- R5: With `frm_err`=1, each inserted framing byte has its bit 0 inverted (0xF7, 0x29).
- R6: With `b1_ins`=1, position 1080 (row 2, first overhead byte) carries the XOR of all 9720 transmitted bytes of the previous frame, taken after scrambling. The first frame after the first pulse following reset carries 0x00.
- R7: With `b1_err`=1, the inserted B1 byte has its bit 0 inverted.
- R8: With `scr_on`=1, positions 36 to 9719 are XORed with the keystream of generator 1 + x^6 + x^7. The keystream is reloaded to all ones at position 36 and used MSB first, so its first byte is 0xFE. Positions 0 to 35 are never scrambled. Scrambling acts on bytes after insertion, B1 included.
- R9: A pulse accepted at a position other than 0 restarts the frame at position 0, and that new frame's B1 carries 0x00.
- R10: With only `frm_ins` enabled, every byte outside positions 0 to 23 leaves unchanged.
- R11: With `thru`=1, every output byte equals its input byte regardless of the other controls.
- R12: With every stage control at 0, every output byte equals its input byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Payload byte |
| in_par | input | 1 | Parity bit of `in_data` |
| in_sof | input | 1 | Frame pulse, marks the byte as position 0 |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Processed byte |
| out_perr | output | 1 | Parity failure of this byte's input |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| frm_ins | input | 1 | Overwrite framing bytes |
| frm_err | input | 1 | Corrupt inserted framing bytes |
| b1_ins | input | 1 | Overwrite B1 with previous frame's BIP-8 |
| b1_err | input | 1 | Corrupt inserted B1 |
| scr_on | input | 1 | Enable frame-synchronous scrambling |
| thru | input | 1 | Pass every byte unchanged |

## Verification
The properties assume that `in_sof` and the stage controls have meaning only on clocks where a byte is accepted. They also assume the controls stay fixed across the accepting edge. The stimulus changes controls only between bytes, once the previous byte has been taken. It raises the pulse only together with a valid byte, and it asserts reset with the input idle. The tests drive the output side both continuously ready and with irregular stalls, so the hold-while-stalled and one-clock-latency properties are exercised in both conditions.

// File: rtl/sts_oh_pkg.sv
`timescale 1ns/1ps
package sts_oh_pkg;

  localparam int BYTE_W = 8;
  localparam int SCR_W  = 7;

  localparam logic [BYTE_W-1:0] A1_BYTE  = 8'hF6;
  localparam logic [BYTE_W-1:0] A2_BYTE  = 8'h28;
  localparam logic [SCR_W-1:0]  SCR_SEED = 7'h7F;

  typedef struct packed {
    logic frm_ins;
    logic frm_err;
    logic b1_ins;
    logic b1_err;
    logic scr_on;
    logic thru;
  } stage_ctl_t;

  // Keystream byte for a given generator state, first bit in the MSB.
  function automatic logic [BYTE_W-1:0] scr_key(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0]  t;
    logic [BYTE_W-1:0] k;
    t = s;
    k = '0;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      k[i] = t[SCR_W-1];
      t    = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
    end
    return k;
  endfunction

  // Generator state after one byte of keystream.
  function automatic logic [SCR_W-1:0] scr_step(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0] t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) begin
      t = {t[SCR_W-2:0], t[SCR_W-1] ^ t[SCR_W-2]};
    end
    return t;
  endfunction

endpackage

// File: rtl/frame_tracker.sv
`timescale 1ns/1ps
module frame_tracker #(
  parameter int FRAME_LEN = 9720,
  parameter int POS_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             fp,
  output logic [POS_W-1:0] cur_pos,
  output logic             locked,
  output logic             start,
  output logic             clean
);

  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] cnt;
  logic             synced;

  // A pulse forces position 0; otherwise the free-running count applies.
  assign cur_pos = fp ? '0 : cnt;
  assign locked  = synced | fp;
  assign start   = locked & (cur_pos == '0);
  // A start is clean when the previous frame ran its full length.
  assign clean   = synced & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      synced <= 1'b0;
    end else if (adv) begin
      cnt <= (cur_pos == LAST) ? '0 : cur_pos + 1'b1;
      if (fp) synced <= 1'b1;
    end
  end

endmodule

// File: rtl/oh_insert.sv
`timescale 1ns/1ps
module oh_insert
  import sts_oh_pkg::*;
#(
  parameter int POS_W  = 14,
  parameter int A_CNT  = 12,
  parameter int B1_POS = 1080
) (
  input  logic [POS_W-1:0]  cur_pos,
  input  logic              locked,
  input  stage_ctl_t        ctl,
  input  logic [BYTE_W-1:0] din,
  input  logic [BYTE_W-1:0] b1_val,
  output logic [BYTE_W-1:0] dout
);

  localparam logic [POS_W-1:0] A1_END = POS_W'(A_CNT);
  localparam logic [POS_W-1:0] A2_END = POS_W'(2 * A_CNT);
  localparam logic [POS_W-1:0] B1_P   = POS_W'(B1_POS);

  logic [BYTE_W-1:0] frm_mask;
  logic [BYTE_W-1:0] b1_mask;

  assign frm_mask = {{(BYTE_W-1){1'b0}}, ctl.frm_err};
  assign b1_mask  = {{(BYTE_W-1){1'b0}}, ctl.b1_err};

  always_comb begin
    dout = din;
    if (!ctl.thru && locked) begin
      if (ctl.frm_ins && cur_pos < A1_END) begin
        dout = A1_BYTE ^ frm_mask;
      end else if (ctl.frm_ins && cur_pos < A2_END) begin
        dout = A2_BYTE ^ frm_mask;
      end else if (ctl.b1_ins && cur_pos == B1_P) begin
        dout = b1_val ^ b1_mask;
      end
    end
  end

endmodule

// File: rtl/tx_scrambler.sv
`timescale 1ns/1ps
module tx_scrambler
  import sts_oh_pkg::*;
#(
  parameter int POS_W     = 14,
  parameter int SCR_START = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic              locked,
  input  logic              enable,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);

  localparam logic [POS_W-1:0] START_P = POS_W'(SCR_START);

  logic [SCR_W-1:0] lfsr;
  logic [SCR_W-1:0] state_now;
  logic             in_region;

  assign in_region = locked & (cur_pos >= START_P);
  assign state_now = (cur_pos == START_P) ? SCR_SEED : lfsr;
  assign dout      = (enable && in_region) ? (din ^ scr_key(state_now)) : din;

  // The generator runs by position whether or not scrambling is enabled.
  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr <= SCR_SEED;
    end else if (adv && in_region) begin
      lfsr <= scr_step(state_now);
    end
  end

endmodule

// File: rtl/bip8_acc.sv
`timescale 1ns/1ps
module bip8_acc
  import sts_oh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              start,
  input  logic              clean,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] hold
);

  logic [BYTE_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      hold <= '0;
    end else if (adv) begin
      acc <= start ? din : (acc ^ din);
      if (start) hold <= clean ? acc : '0;
    end
  end

endmodule

// File: rtl/sonet_tx_oh_inserter.sv
`timescale 1ns/1ps
module sonet_tx_oh_inserter
  import sts_oh_pkg::*;
#(
  parameter int STS_N     = 12,
  parameter int STS1_COLS = 90,
  parameter int ROWS      = 9,
  parameter int TOH_COLS  = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_par,
  input  logic       in_sof,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_perr,
  input  logic       par_odd,
  input  logic       frm_ins,
  input  logic       frm_err,
  input  logic       b1_ins,
  input  logic       b1_err,
  input  logic       scr_on,
  input  logic       thru
);

  localparam int ROW_LEN   = STS1_COLS * STS_N;
  localparam int FRAME_LEN = ROW_LEN * ROWS;
  localparam int TOH_ROW   = TOH_COLS * STS_N;
  localparam int POS_W     = $clog2(FRAME_LEN);

  logic              adv;
  logic [POS_W-1:0]  cur_pos;
  logic              locked;
  logic              start;
  logic              clean;
  logic [BYTE_W-1:0] b1_val;
  logic [BYTE_W-1:0] ins_byte;
  logic [BYTE_W-1:0] scr_byte;
  logic              perr;
  stage_ctl_t        ctl;

  assign in_ready = ~out_valid | out_ready;
  assign adv      = in_valid & in_ready;
  assign perr     = (^{in_data, in_par}) ^ par_odd;

  assign ctl = '{frm_ins: frm_ins, frm_err: frm_err, b1_ins: b1_ins,
                 b1_err: b1_err, scr_on: scr_on, thru: thru};

  frame_tracker #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_trk (
    .clk(clk), .rst(rst), .adv(adv), .fp(in_sof),
    .cur_pos(cur_pos), .locked(locked), .start(start), .clean(clean)
  );

  oh_insert #(.POS_W(POS_W), .A_CNT(STS_N), .B1_POS(ROW_LEN)) u_ins (
    .cur_pos(cur_pos), .locked(locked), .ctl(ctl),
    .din(in_data), .b1_val(b1_val), .dout(ins_byte)
  );

  tx_scrambler #(.POS_W(POS_W), .SCR_START(TOH_ROW)) u_scr (
    .clk(clk), .rst(rst), .adv(adv), .cur_pos(cur_pos), .locked(locked),
    .enable(ctl.scr_on & ~ctl.thru), .din(ins_byte), .dout(scr_byte)
  );

  bip8_acc u_bip (
    .clk(clk), .rst(rst), .adv(adv), .start(start), .clean(clean),
    .din(scr_byte), .hold(b1_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_perr  <= 1'b0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data  <= scr_byte;
      out_perr  <= perr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sonet_tx_oh_inserter_chk.sv
`timescale 1ns/1ps
module sonet_tx_oh_inserter_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_par,
  input logic       in_sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_perr,
  input logic       par_odd,
  input logic       frm_ins,
  input logic       frm_err,
  input logic       thru
);

  p_stall_hold_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_perr));

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_parity_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=>
      out_perr == ((^$past({in_data, in_par})) != $past(par_odd)));

  p_framing_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_sof && frm_ins && !frm_err && !thru |=>
      out_data == 8'hF6);

  p_passthru_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && thru |=> out_data == $past(in_data));

endmodule

bind sonet_tx_oh_inserter sonet_tx_oh_inserter_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_par(in_par), .in_sof(in_sof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_perr(out_perr), .par_odd(par_odd), .frm_ins(frm_ins),
  .frm_err(frm_err), .thru(thru)
);

// File: tb/sonet_tx_oh_inserter_test.sv
`timescale 1ns/1ps
module sonet_tx_oh_inserter_test;

  localparam int N         = 12;
  localparam int ROW_LEN   = 1080;
  localparam int FRAME_LEN = 9720;
  localparam int TOH_ROW   = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst;
  logic       in_valid, in_ready, in_par, in_sof;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_perr;
  logic [7:0] out_data;
  logic       par_odd, frm_ins, frm_err, b1_ins, b1_err, scr_on, thru;
  bit         stall_on;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] q_data[$];
  logic       q_perr[$];
  string      q_tag[$];

  // Bench model state
  int         m_cnt;
  bit         m_sync;
  logic [7:0] m_acc;
  logic [7:0] m_hold;
  string      m_hold_tag;
  bit         m_wrap_frame;
  logic [6:0] m_lfsr;

  sonet_tx_oh_inserter uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par(in_par), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_perr(out_perr), .par_odd(par_odd), .frm_ins(frm_ins),
    .frm_err(frm_err), .b1_ins(b1_ins), .b1_err(b1_err),
    .scr_on(scr_on), .thru(thru)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] key_of(input logic [6:0] s);
    logic [6:0] t = s;
    logic [7:0] k = '0;
    for (int i = 7; i >= 0; i--) begin
      k[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    return k;
  endfunction

  function automatic logic [6:0] step_of(input logic [6:0] s);
    logic [6:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[5:0], t[6] ^ t[5]};
    return t;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_sync = 0; m_acc = '0; m_hold = '0;
    m_hold_tag = "R6"; m_wrap_frame = 0; m_lfsr = 7'h7F;
  endtask

  task automatic predict(input logic [7:0] d, input logic p, input logic fp);
    int cur;
    bit insync, start, clean;
    logic [7:0] b;
    logic [6:0] st;
    string tag;
    cur    = fp ? 0 : m_cnt;
    insync = m_sync || fp;
    start  = insync && (cur == 0);
    clean  = m_sync && (m_cnt == 0);
    if (start) begin
      m_wrap_frame = !fp;
      if (clean) begin m_hold = m_acc; m_hold_tag = "R6"; end
      else begin m_hold = '0; m_hold_tag = m_sync ? "R9" : "R6"; end
    end
    b = d;
    if (frm_ins && !frm_err && !b1_ins && !scr_on) tag = "R10";
    else tag = "R12";
    if (thru) begin
      tag = "R11";
    end else if (!insync) begin
      tag = "R3";
    end else begin
      if (frm_ins && cur < N) begin
        b = 8'hF6 ^ {7'b0, frm_err};
        tag = frm_err ? "R5" : (m_wrap_frame ? "R3" : "R4");
      end else if (frm_ins && cur < 2 * N) begin
        b = 8'h28 ^ {7'b0, frm_err};
        tag = frm_err ? "R5" : "R4";
      end else if (b1_ins && cur == ROW_LEN) begin
        b = m_hold ^ {7'b0, b1_err};
        tag = b1_err ? "R7" : m_hold_tag;
      end else if (scr_on && cur >= TOH_ROW) begin
        tag = "R8";
      end
    end
    if (insync && cur >= TOH_ROW) begin
      st = (cur == TOH_ROW) ? 7'h7F : m_lfsr;
      if (scr_on && !thru) b = b ^ key_of(st);
      m_lfsr = step_of(st);
    end
    m_acc = start ? b : (m_acc ^ b);
    m_cnt = (cur == FRAME_LEN - 1) ? 0 : cur + 1;
    if (fp) m_sync = 1;
    q_data.push_back(b);
    q_perr.push_back((^{d, p}) != par_odd);
    q_tag.push_back(tag);
  endtask

  task automatic push_byte(input logic [7:0] d, input bit bad_par, input logic fp);
    logic p;
    bit rdy;
    p = par_odd ? ~^d : ^d;
    if (bad_par) p = ~p;
    predict(d, p, fp);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_par = p; in_sof = fp;
    forever begin
      #1;
      rdy = in_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    while (q_data.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_ctl(input bit fi, input bit fe, input bit bi, input bit be,
                         input bit sc, input bit th);
    frm_ins = fi; frm_err = fe; b1_ins = bi; b1_err = be; scr_on = sc; thru = th;
  endtask

  task automatic send_run(input int count, input bit first_fp);
    for (int i = 0; i < count; i++)
      push_byte(8'($urandom), 1'b0, first_fp && (i == 0));
  endtask

  // Output monitor: sampled well after the falling edge.
  initial begin
    bit         prev_stall = 0;
    logic [7:0] prev_data  = '0;
    logic       prev_perr  = 1'b0;
    logic [7:0] ed;
    logic       ep;
    string      et;
    forever begin
      @(negedge clk);
      #3;
      if (rst) begin prev_stall = 0; continue; end
      if (prev_stall)
        check(out_valid && out_data == prev_data && out_perr == prev_perr,
              "R1", "held byte under stall", {23'b0, out_valid, out_data},
              {23'b0, 1'b1, prev_data});
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_perr  = out_perr;
      if (out_valid && out_ready) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R1", "unexpected output byte", {24'b0, out_data}, 32'h0);
        end else begin
          ed = q_data.pop_front(); ep = q_perr.pop_front(); et = q_tag.pop_front();
          check(out_data == ed, et, "output byte", {24'b0, out_data}, {24'b0, ed});
          check(out_perr == ep, "R2", "parity flag", {31'b0, out_perr}, {31'b0, ep});
        end
      end
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic t_reset();
    // R1: idle output and ready input after reset
    check(out_valid == 1'b0, "R1", "out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", {31'b0, in_ready}, 32'h1);
  endtask

  task automatic t_presync();
    // R3: no insertion before the first frame pulse
    set_ctl(1, 0, 1, 0, 1, 0);
    send_run(50, 1'b0);
    drain();
  endtask

  task automatic t_transparent();
    // R4 and R10: framing bytes only
    set_ctl(1, 0, 0, 0, 0, 0);
    send_run(300, 1'b1);
    drain();
  endtask

  task automatic t_frame_err();
    // R5: corrupted framing bytes
    set_ctl(1, 1, 0, 0, 0, 0);
    send_run(40, 1'b1);
    drain();
  endtask

  task automatic t_plain();
    // R12: every stage off, B1 slot included
    set_ctl(0, 0, 0, 0, 0, 0);
    send_run(1200, 1'b1);
    drain();
  endtask

  task automatic t_bypass();
    // R11: pass-through with every other control set
    set_ctl(1, 1, 1, 1, 1, 1);
    stall_on = 1;
    send_run(1200, 1'b1);
    drain();
    stall_on = 0;
  endtask

  task automatic t_parity();
    // R2: both senses, injected failures on every third byte
    set_ctl(0, 0, 0, 0, 0, 0);
    for (int m = 0; m < 2; m++) begin
      par_odd = (m == 0);
      for (int i = 0; i < 64; i++)
        push_byte(8'($urandom), (i % 3) == 1, i == 0);
      drain();
    end
    par_odd = 1'b1;
  endtask

  task automatic t_full();
    // R3, R6, R7, R8: full processing over four frames under stalls
    set_ctl(1, 0, 1, 0, 1, 0);
    stall_on = 1;
    for (int i = 0; i < 3 * FRAME_LEN + 1200; i++) begin
      if (i == 3 * FRAME_LEN) b1_err = 1'b1;
      push_byte(8'($urandom), (i % 997) == 5, (i == 0) || (i == 2 * FRAME_LEN));
    end
    b1_err = 1'b0;
  endtask

  task automatic t_misalign();
    // R9: early pulse restarts the frame and voids B1
    set_ctl(1, 0, 1, 0, 1, 0);
    send_run(300, 1'b0);
    send_run(1100, 1'b1);
    drain();
    stall_on = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_par = 1'b0; in_sof = 1'b0;
    par_odd = 1'b1; stall_on = 0;
    set_ctl(0, 0, 0, 0, 0, 0);
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_presync();
    t_transparent();
    t_frame_err();
    t_plain();
    t_bypass();
    t_parity();
    t_full();
    t_misalign();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule